// File: doc/BRIEF.md
# Audio Period Fetch Engine

This block reads one period of 32-bit audio words from memory into a local FIFO that a downstream audio formatter drains. Software programs it through a byte-wide register port. It sets a first-byte address and a last-byte address for the period, picks a burst length, and sets a fill threshold. A launch strobe then starts the transfer. The engine walks the period word by word and issues incrementing read bursts to a simple request/response memory port. Each burst is trimmed so that it never reads past the last byte. A burst goes out only when the FIFO can take all of it and the fill is below the threshold.

When the final word of the period lands in the FIFO, the engine raises a completion cause and goes idle until the next launch. A halt strobe abandons the transfer at any point. Six sticky causes (completion, error, lost response, restart, FIFO full, FIFO empty) sit in a status register that is cleared by writing ones. Each cause can be suppressed by a per-cause mute bit or by the fetch mask. The unsuppressed causes are ORed into a registered, active-high interrupt.

Top module: `apdma_top`

## Requirements
- R1: After reset, irq, memReqValid and fifoLevel are 0. Status (offset 13) reads 0x00, mask (offset 12) reads 0xFF and mute (offset 14) reads 0x3F.
- R2: The first-byte address is held at offsets 4..7 and the last-byte address at offsets 8..11, least significant byte at the lowest offset. Both read back as written.
- R3: Writing a 1 to bit 0 of offset 1 launches a fetch. Requests start at the first-byte address and advance by 4 bytes per word. The words enter the FIFO in address order, and fifoData shows the oldest word. memReqValid, memReqAddr and memReqBeats hold steady until memReqReady.
- R4: Offset 0 holds the configuration. With bit 0 clear, every request is 1 beat. With bit 0 set, bits 2:1 choose 4 beats (0), 8 beats (1) or 16 beats (2 or 3).
- R5: No request reaches past the last-byte address. The final burst of a period is shortened to the words that remain.
- R6: Offset 3 holds the threshold T in units of 32 bytes (8 words). A request is issued only when fifoLevel is below 8*T and fifoLevel plus the burst length fits in the FIFO. Status bit 1 (full) is set when the FIFO becomes full.
- R7: Status bit 2 (done) is set once, when the last word of the period is written into the FIFO. The engine then issues no further requests until the next launch.
- R8: Writing a 1 to bit 0 of offset 2 halts the engine at once. Responses still outstanding are discarded and set status bit 4 (lost). Done is not set.
- R9: Writing a 1 to a status bit clears it. Bits written as 0 keep their value. Status bit 0 (empty) is set when the FIFO level falls to zero.
- R10: irq rises one cycle after a cause that is set, unmuted (mute bit of the same position is 0) and unmasked. Mask bit 7 masks done, and mask bits 5..3, 1 and 0 mask the cause in the same position.
- R11: Writing bit 7 of offset 0 empties the FIFO. That bit is not stored and reads back as 0.
- R12: memReqLock is high with each request whenever configuration bit 3 is set, and low otherwise.
- R13: A response flagged memRspErr sets status bit 5 (error). A launch while the engine is busy sets status bit 3 (retry) and restarts the fetch from the first-byte address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 4 | Register offset |
| regWdata | input | 8 | Register write data |
| regRdata | output | 8 | Register read data (combinational) |
| memReqValid | output | 1 | Burst request valid |
| memReqReady | input | 1 | Burst request accepted |
| memReqAddr | output | 32 | Burst byte address |
| memReqBeats | output | 5 | Burst length in words |
| memReqLock | output | 1 | Bus lock request |
| memRspValid | input | 1 | Response word valid |
| memRspData | input | 32 | Response word |
| memRspErr | input | 1 | Response error flag |
| fifoPop | input | 1 | Remove the oldest FIFO word |
| fifoData | output | 32 | Oldest FIFO word |
| fifoLevel | output | 7 | Words held in the FIFO |
| irq | output | 1 | Interrupt, active high |

## Verification
A wrong address counter shows up as a wrong memReqAddr on the next request and as out-of-order words at fifoData once the FIFO is drained. A wrong remaining-word count shows up as a wrong burst length or a missing done bit at the end of the period. Gating faults show within one burst time: fifoLevel settles at a value other than the threshold or the depth, or an extra request appears. A fault in the status or interrupt path shows one cycle after the cause, as an irq level that disagrees with the mute and mask settings.

// File: rtl/apdma_pkg.sv
package apdma_pkg;
  localparam int BEAT_W = 5;

  typedef struct packed {
    logic flush;
    logic loadAddr;
    logic push;
  } dpStrobe_t;

  typedef enum logic [1:0] {ST_IDLE, ST_ARM, ST_REQ, ST_RECV} engState_t;

  localparam logic [3:0] RA_CFG   = 4'd0;
  localparam logic [3:0] RA_GO    = 4'd1;
  localparam logic [3:0] RA_HALT  = 4'd2;
  localparam logic [3:0] RA_THR   = 4'd3;
  localparam logic [3:0] RA_START = 4'd4;
  localparam logic [3:0] RA_STOP  = 4'd8;
  localparam logic [3:0] RA_MASK  = 4'd12;
  localparam logic [3:0] RA_STAT  = 4'd13;
  localparam logic [3:0] RA_MUTE  = 4'd14;
endpackage

// File: rtl/apdma_datapath.sv
module apdma_datapath
  import apdma_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int FIFO_DEPTH = 64,
  localparam int LVL_W     = $clog2(FIFO_DEPTH + 1),
  localparam int WORD_W    = ADDR_W - 2,
  localparam int LEFT_W    = ADDR_W - 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [WORD_W-1:0] startWord,
  input  logic [WORD_W-1:0] stopWord,
  input  logic [DATA_W-1:0] rspData,
  input  logic              pop,
  output logic [WORD_W-1:0] curWord,
  output logic [LEFT_W-1:0] wordsLeft,
  output logic [DATA_W-1:0] headData,
  output logic [LVL_W-1:0]  level
);
  localparam int PTR_W = $clog2(FIFO_DEPTH);

  logic [DATA_W-1:0] mem [FIFO_DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic              doPush, doPop;

  assign doPush = strobe.push && !strobe.flush;
  assign doPop  = pop && (level != '0) && !strobe.flush;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                curWord <= '0;
    else if (strobe.loadAddr) curWord <= startWord;
    else if (strobe.push)     curWord <= curWord + WORD_W'(1);
  end

  assign wordsLeft = (curWord > stopWord) ? '0
                   : LEFT_W'(stopWord - curWord) + LEFT_W'(1);

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= rspData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else if (strobe.flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else begin
      wrPtr <= wrPtr + PTR_W'(doPush);
      rdPtr <= rdPtr + PTR_W'(doPop);
      level <= level + LVL_W'(doPush) - LVL_W'(doPop);
    end
  end

  assign headData = mem[rdPtr];

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    strobe.push |-> (level < LVL_W'(FIFO_DEPTH))); // R6
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    strobe.flush |=> (level == '0)); // R11
endmodule

// File: rtl/apdma_ctrl.sv
module apdma_ctrl
  import apdma_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int FIFO_DEPTH = 64,
  parameter int THR_BYTES  = 32,
  localparam int LVL_W     = $clog2(FIFO_DEPTH + 1),
  localparam int WORD_W    = ADDR_W - 2,
  localparam int LEFT_W    = ADDR_W - 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [3:0]        regAddr,
  input  logic [7:0]        regWdata,
  output logic [7:0]        regRdata,
  input  logic              reqReady,
  input  logic              rspValid,
  input  logic              rspErr,
  input  logic [WORD_W-1:0] curWord,
  input  logic [LEFT_W-1:0] wordsLeft,
  input  logic [LVL_W-1:0]  level,
  output dpStrobe_t         strobe,
  output logic [WORD_W-1:0] startWord,
  output logic [WORD_W-1:0] stopWord,
  output logic              reqValid,
  output logic [ADDR_W-1:0] reqAddr,
  output logic [BEAT_W-1:0] reqBeats,
  output logic              reqLock,
  output logic              irq
);
  localparam int ADDR_BYTES = ADDR_W / 8;
  localparam int THR_SHIFT  = $clog2(THR_BYTES / 4);

  logic [3:0]        cfgQ;
  logic [7:0]        thrQ, maskQ;
  logic [5:0]        muteQ, statQ, setVec, clrVec, maskEff;
  logic [ADDR_W-1:0] startQ, stopQ;
  engState_t         stateQ, stateD;
  logic [BEAT_W-1:0] beatsQ, beatsD, beatsLeftQ, beatsLeftD, burstLen, beatsNext;
  logic              emptyQ, fullQ, irqQ;
  logic              goStb, haltStb, loadStb, pushStb, doneSet, retrySet, lostSet, errSet;
  logic              canIssue;

  assign goStb   = regWr && regAddr == RA_GO   && regWdata[0];
  assign haltStb = regWr && regAddr == RA_HALT && regWdata[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ  <= '0;
      thrQ  <= 8'h80;
      maskQ <= 8'hFF;
      muteQ <= 6'h3F;
    end else if (regWr) begin
      case (regAddr)
        RA_CFG:  cfgQ  <= regWdata[3:0];
        RA_THR:  thrQ  <= regWdata;
        RA_MASK: maskQ <= regWdata;
        RA_MUTE: muteQ <= regWdata[5:0];
        default: ;
      endcase
    end
  end

  for (genvar b = 0; b < ADDR_BYTES; b++) begin : g_addrByte
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        startQ[8*b +: 8] <= '0;
        stopQ[8*b +: 8]  <= '0;
      end else if (regWr) begin
        if (regAddr == 4'(RA_START + b)) startQ[8*b +: 8] <= regWdata;
        if (regAddr == 4'(RA_STOP + b))  stopQ[8*b +: 8]  <= regWdata;
      end
    end
  end

  assign startWord = startQ[ADDR_W-1:2];
  assign stopWord  = stopQ[ADDR_W-1:2];

  always_comb begin
    if (!cfgQ[0])            burstLen = BEAT_W'(1);
    else if (cfgQ[2:1] == 0) burstLen = BEAT_W'(4);
    else if (cfgQ[2:1] == 1) burstLen = BEAT_W'(8);
    else                     burstLen = BEAT_W'(16);
  end

  assign beatsNext = (wordsLeft < LEFT_W'(burstLen)) ? BEAT_W'(wordsLeft) : burstLen;
  assign canIssue  = (32'(level) < (32'(thrQ) << THR_SHIFT)) &&
                     (32'(level) + 32'(beatsNext) <= 32'(FIFO_DEPTH));

  always_comb begin
    stateD     = stateQ;
    beatsD     = beatsQ;
    beatsLeftD = beatsLeftQ;
    loadStb    = 1'b0;
    pushStb    = 1'b0;
    doneSet    = 1'b0;
    retrySet   = 1'b0;
    if (haltStb) begin
      stateD = ST_IDLE;
    end else if (goStb) begin
      loadStb  = 1'b1;
      retrySet = (stateQ != ST_IDLE);
      stateD   = ST_ARM;
    end else begin
      case (stateQ)
        ST_ARM: begin
          if (wordsLeft == '0) begin
            doneSet = 1'b1;
            stateD  = ST_IDLE;
          end else if (canIssue) begin
            beatsD = beatsNext;
            stateD = ST_REQ;
          end
        end
        ST_REQ: begin
          if (reqReady) begin
            beatsLeftD = beatsQ;
            stateD     = ST_RECV;
          end
        end
        ST_RECV: begin
          if (rspValid) begin
            pushStb    = 1'b1;
            beatsLeftD = beatsLeftQ - BEAT_W'(1);
            if (beatsLeftQ == BEAT_W'(1)) begin
              if (wordsLeft == LEFT_W'(1)) begin
                doneSet = 1'b1;
                stateD  = ST_IDLE;
              end else begin
                stateD = ST_ARM;
              end
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ     <= ST_IDLE;
      beatsQ     <= '0;
      beatsLeftQ <= '0;
    end else begin
      stateQ     <= stateD;
      beatsQ     <= beatsD;
      beatsLeftQ <= beatsLeftD;
    end
  end

  assign strobe.flush    = regWr && regAddr == RA_CFG && regWdata[7];
  assign strobe.loadAddr = loadStb;
  assign strobe.push     = pushStb;

  assign lostSet = rspValid && stateQ != ST_RECV;
  assign errSet  = rspValid && rspErr && stateQ == ST_RECV;
  assign setVec  = {errSet, lostSet, retrySet, doneSet,
                    level == LVL_W'(FIFO_DEPTH) && !fullQ, level == '0 && !emptyQ};
  assign clrVec  = (regWr && regAddr == RA_STAT) ? regWdata[5:0] : 6'b0;
  assign maskEff = {maskQ[5:3], maskQ[7], maskQ[1:0]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statQ  <= '0;
      emptyQ <= 1'b1;
      fullQ  <= 1'b0;
      irqQ   <= 1'b0;
    end else begin
      statQ  <= (statQ & ~clrVec) | setVec;
      emptyQ <= (level == '0);
      fullQ  <= (level == LVL_W'(FIFO_DEPTH));
      irqQ   <= |(statQ & ~muteQ & ~maskEff);
    end
  end

  assign irq      = irqQ;
  assign reqValid = (stateQ == ST_REQ);
  assign reqAddr  = {curWord, 2'b00};
  assign reqBeats = beatsQ;
  assign reqLock  = reqValid && cfgQ[3];

  always_comb begin
    regRdata = '0;
    case (regAddr)
      RA_CFG:  regRdata = {4'b0, cfgQ};
      RA_THR:  regRdata = thrQ;
      RA_MASK: regRdata = maskQ;
      RA_STAT: regRdata = {2'b0, statQ};
      RA_MUTE: regRdata = {2'b0, muteQ};
      default: ;
    endcase
    for (int b = 0; b < ADDR_BYTES; b++) begin
      if (regAddr == 4'(RA_START + b)) regRdata = startQ[8*b +: 8];
      if (regAddr == 4'(RA_STOP + b))  regRdata = stopQ[8*b +: 8];
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && !reqReady && !haltStb && !goStb |=> reqValid && $stable(reqAddr) && $stable(reqBeats)); // R3
  AST_BEATS_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> (reqBeats >= BEAT_W'(1)) && (reqBeats <= BEAT_W'(16))); // R4
  AST_NO_CROSS: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> ((ADDR_W+1)'(curWord) + (ADDR_W+1)'(reqBeats) <= (ADDR_W+1)'(stopWord) + (ADDR_W+1)'(1))); // R5
  AST_HALT_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    haltStb |=> !reqValid && !strobe.push); // R8
endmodule

// File: rtl/apdma_top.sv
module apdma_top
  import apdma_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int FIFO_DEPTH = 64,
  parameter int THR_BYTES  = 32,
  localparam int LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [3:0]        regAddr,
  input  logic [7:0]        regWdata,
  output logic [7:0]        regRdata,
  output logic              memReqValid,
  input  logic              memReqReady,
  output logic [ADDR_W-1:0] memReqAddr,
  output logic [BEAT_W-1:0] memReqBeats,
  output logic              memReqLock,
  input  logic              memRspValid,
  input  logic [DATA_W-1:0] memRspData,
  input  logic              memRspErr,
  input  logic              fifoPop,
  output logic [DATA_W-1:0] fifoData,
  output logic [LVL_W-1:0]  fifoLevel,
  output logic              irq
);
  dpStrobe_t           strobe;
  logic [ADDR_W-3:0]   curWord, startWord, stopWord;
  logic [ADDR_W-2:0]   wordsLeft;

  apdma_ctrl #(.ADDR_W(ADDR_W), .FIFO_DEPTH(FIFO_DEPTH), .THR_BYTES(THR_BYTES)) uCtrl (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .reqReady(memReqReady), .rspValid(memRspValid), .rspErr(memRspErr),
    .curWord(curWord), .wordsLeft(wordsLeft), .level(fifoLevel), .strobe(strobe),
    .startWord(startWord), .stopWord(stopWord), .reqValid(memReqValid), .reqAddr(memReqAddr),
    .reqBeats(memReqBeats), .reqLock(memReqLock), .irq(irq)
  );

  apdma_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .FIFO_DEPTH(FIFO_DEPTH)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .startWord(startWord), .stopWord(stopWord),
    .rspData(memRspData), .pop(fifoPop), .curWord(curWord), .wordsLeft(wordsLeft),
    .headData(fifoData), .level(fifoLevel)
  );
endmodule

// File: tb/sim_apdma_top.sv
module sim_apdma_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] PAT = 32'h5A5A0000;
  localparam int NVEC = 7;
  localparam int V_START [NVEC] = '{32'h1000, 32'h2000, 32'h3004, 32'h4000, 32'h5000, 32'h6000, 32'h7FFC};
  localparam int V_LEN   [NVEC] = '{8, 10, 20, 16, 20, 3, 1};
  localparam int V_SEL   [NVEC] = '{0, 0, 1, 2, 3, 0, 2};
  localparam int V_BEN   [NVEC] = '{1, 1, 1, 1, 1, 0, 1};
  localparam int V_NREQ  [NVEC] = '{2, 3, 3, 1, 2, 3, 1};

  logic clk = 0, rstN = 0, regWr = 0, fifoPop = 0;
  logic [3:0] regAddr = 0;
  logic [7:0] regWdata = 0, regRdata;
  logic memReqValid, memReqLock, memRspValid, memRspErr, irq;
  logic memReqReady = 1;
  logic [31:0] memReqAddr, memRspData, fifoData;
  logic [4:0] memReqBeats;
  logic [6:0] fifoLevel;

  int total = 0, bad = 0, reqCnt = 0, rspDelay = 0;
  logic errKnob = 0;
  logic [31:0] reqAddrLog [64];
  int reqBeatsLog [64];
  logic reqLockLog [64];

  apdma_top u0 (.clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .memReqValid(memReqValid), .memReqReady(memReqReady),
    .memReqAddr(memReqAddr), .memReqBeats(memReqBeats), .memReqLock(memReqLock),
    .memRspValid(memRspValid), .memRspData(memRspData), .memRspErr(memRspErr),
    .fifoPop(fifoPop), .fifoData(fifoData), .fifoLevel(fifoLevel), .irq(irq));

  initial forever #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    int pendBeats, waitCnt;
    logic [31:0] pendAddr;
    pendBeats = 0; waitCnt = 0; pendAddr = 0;
    memRspValid = 0; memRspData = 0; memRspErr = 0;
    forever begin
      @(negedge clk);
      if (pendBeats > 0) begin
        if (waitCnt > 0) begin
          waitCnt--;
          memRspValid = 0;
        end else begin
          memRspValid = 1;
          memRspData  = pendAddr ^ PAT;
          memRspErr   = errKnob;
          pendAddr    = pendAddr + 4;
          pendBeats--;
        end
      end else begin
        memRspValid = 0;
        memRspErr   = 0;
        if (rstN && memReqValid && memReqReady) begin
          if (reqCnt < 64) begin
            reqAddrLog[reqCnt]  = memReqAddr;
            reqBeatsLog[reqCnt] = int'(memReqBeats);
            reqLockLog[reqCnt]  = memReqLock;
          end
          reqCnt++;
          pendBeats = int'(memReqBeats);
          pendAddr  = memReqAddr;
          waitCnt   = rspDelay;
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    bad++;
    total++;
    $display("FAIL watchdog: run did not finish act=hung exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    regWr = 1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWr = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdata;
  endtask

  task automatic waitCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setPeriod(input logic [31:0] first, input logic [31:0] last);
    for (int b = 0; b < 4; b++) wr(4'(4 + b), first[8*b +: 8]);
    for (int b = 0; b < 4; b++) wr(4'(8 + b), last[8*b +: 8]);
  endtask

  task automatic popWord(output logic [31:0] d);
    @(negedge clk);
    d = fifoData;
    fifoPop = 1;
    @(negedge clk);
    fifoPop = 0;
  endtask

  function automatic int burstOf(input int ben, input int sel);
    if (ben == 0) return 1;
    if (sel == 0) return 4;
    if (sel == 1) return 8;
    return 16;
  endfunction

  initial begin
    logic [7:0] s;
    logic [31:0] w;
    repeat (3) @(negedge clk);
    rstN = 1;

    // R1 reset state
    check("R1 irq", irq, 0);
    check("R1 reqValid", memReqValid, 0);
    check("R1 level", fifoLevel, 0);
    rd(4'd13, s); check("R1 status", s, 8'h00);
    rd(4'd12, s); check("R1 mask", s, 8'hFF);
    rd(4'd14, s); check("R1 mute", s, 8'h3F);

    // Table of periods: R3 order/address, R4 burst length, R5 trimming, R7 done, R12 lock
    for (int i = 0; i < NVEC; i++) begin
      int lockOn, rem, bl;
      logic [31:0] ea;
      lockOn = i % 2;
      wr(4'd0, 8'h80);
      wr(4'd0, 8'(V_BEN[i] | (V_SEL[i] << 1) | (lockOn << 3)));
      wr(4'd3, 8'h80);
      setPeriod(V_START[i], V_START[i] + 4 * V_LEN[i] - 1);
      wr(4'd13, 8'h3F);
      reqCnt = 0;
      wr(4'd1, 8'h01);
      for (int t = 0; t < 500; t++) begin
        rd(4'd13, s);
        if (s[2]) break;
      end
      check("R7 done set", s[2], 1);
      check("R3 request count", reqCnt, V_NREQ[i]);
      rem = V_LEN[i];
      ea = V_START[i];
      for (int k = 0; k < reqCnt && k < 64; k++) begin
        bl = burstOf(V_BEN[i], V_SEL[i]);
        if (bl > rem) bl = rem;            // R5 trimmed final burst
        check("R3 request address", reqAddrLog[k], ea);
        check("R4 R5 request beats", reqBeatsLog[k], bl);
        check("R12 lock", reqLockLog[k], lockOn);
        rem -= bl;
        ea += 4 * bl;
      end
      check("R3 fifo level", fifoLevel, V_LEN[i]);
      for (int k = 0; k < V_LEN[i]; k++) begin
        popWord(w);
        check("R3 fifo data", w, (V_START[i] + 4 * k) ^ PAT);
      end
      wr(4'd13, 8'h04);
      waitCycles(10);
      rd(4'd13, s);
      check("R7 done once", s[2], 0);
      check("R9 empty kept after clearing done", s[0], 1);
      check("R7 idle after done", memReqValid, 0);
      check("R7 no extra request", reqCnt, V_NREQ[i]);
    end

    // R10 interrupt path
    wr(4'd14, 8'h3B);
    wr(4'd12, 8'hFF);
    wr(4'd0, 8'h00);
    setPeriod(32'hB000, 32'hB007);
    wr(4'd13, 8'h3F);
    wr(4'd1, 8'h01);
    waitCycles(20);
    rd(4'd13, s); check("R10 done present", s[2], 1);
    check("R10 masked irq low", irq, 0);
    wr(4'd12, 8'h7F);
    waitCycles(1);
    check("R10 unmasked irq high", irq, 1);
    wr(4'd13, 8'h04);
    waitCycles(1);
    check("R10 irq low after clear", irq, 0);
    wr(4'd12, 8'hFF);
    wr(4'd14, 8'h3F);
    wr(4'd0, 8'h80);

    // R6 threshold gate, R13 retry, R11 flush
    wr(4'd0, 8'h01);
    wr(4'd3, 8'h01);
    setPeriod(32'h8000, 32'h803F);
    wr(4'd13, 8'h3F);
    reqCnt = 0;
    wr(4'd1, 8'h01);
    waitCycles(40);
    check("R6 threshold requests", reqCnt, 2);
    check("R6 threshold level", fifoLevel, 8);
    popWord(w);
    check("R3 first word", w, 32'h8000 ^ PAT);
    waitCycles(20);
    check("R6 refill after pop", reqCnt, 3);
    check("R6 refill level", fifoLevel, 11);
    wr(4'd1, 8'h01);
    rd(4'd13, s); check("R13 retry", s[3], 1);
    wr(4'd2, 8'h01);
    waitCycles(5);
    wr(4'd0, 8'h81);
    check("R11 flush empties", fifoLevel, 0);
    rd(4'd0, s); check("R11 flush bit self clears", s, 8'h01);
    waitCycles(20);
    check("R8 no request after halt", reqCnt, 3);

    // R6 room gate and full cause, R2 byte order
    wr(4'd3, 8'h80);
    wr(4'd0, 8'h05);
    setPeriod(32'h9000, 32'h913F);
    rd(4'd4, s); check("R2 start byte0", s, 8'h00);
    rd(4'd5, s); check("R2 start byte1", s, 8'h90);
    rd(4'd8, s); check("R2 stop byte0", s, 8'h3F);
    rd(4'd9, s); check("R2 stop byte1", s, 8'h91);
    wr(4'd13, 8'h3F);
    reqCnt = 0;
    wr(4'd1, 8'h01);
    waitCycles(120);
    check("R6 room requests", reqCnt, 4);
    check("R6 full level", fifoLevel, 64);
    rd(4'd13, s); check("R6 full cause", s[1], 1);
    wr(4'd0, 8'h85);
    waitCycles(40);
    check("R6 resume after flush", reqCnt, 5);
    check("R6 tail level", fifoLevel, 16);
    rd(4'd13, s); check("R7 done after tail", s[2], 1);
    wr(4'd0, 8'h81);

    // R8 halt while responses are outstanding
    rspDelay = 8;
    setPeriod(32'hA000, 32'hA01F);
    wr(4'd13, 8'h3F);
    reqCnt = 0;
    wr(4'd1, 8'h01);
    for (int t = 0; t < 50 && reqCnt == 0; t++) @(negedge clk);
    wr(4'd2, 8'h01);
    waitCycles(30);
    rspDelay = 0;
    check("R8 dropped words", fifoLevel, 0);
    rd(4'd13, s);
    check("R8 no done", s[2], 0);
    check("R8 lost cause", s[4], 1);
    check("R8 single request", reqCnt, 1);
    check("R8 idle", memReqValid, 0);

    // R13 error cause
    errKnob = 1;
    wr(4'd0, 8'h80);
    setPeriod(32'hC000, 32'hC007);
    wr(4'd13, 8'h3F);
    wr(4'd1, 8'h01);
    waitCycles(20);
    errKnob = 0;
    rd(4'd13, s);
    check("R13 error cause", s[5], 1);
    check("R13 done despite error", s[2], 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule